// File: doc/BRIEF.md
# Adaptive-Gain Rate Estimator

This block predicts the next value of a sampled quantity, such as an arrival rate or a per-item execution time, in unsigned Q8.8 fixed point. Each accepted sample goes into an eight-entry sliding window of observations. The block also measures how far its previous prediction was from the new observation and smooths that error, using a designer-set coefficient, against the mean of an eight-entry window of past errors. The smoothed error then goes into the error window.

The smoothing gain is recomputed for every sample. It is one minus the smoothed error divided by the largest error held in the error window, and the division runs on a sequential restoring divider. The prediction blends the mean of the earlier observations with the current one using that gain. When the gain is high the prediction follows the history; when it is low the prediction follows the newest sample.

Samples arrive on a valid/ready stream. Only one sample is in flight at a time. `in_ready` stays low from acceptance until the result has been taken on the output stream. The output holds its data while `out_ready` is low, so a slow consumer stalls the estimator and no sample is lost. The coefficient input is a plain configuration pin.

Top module: `adaptive_rate_est`

## Requirements
- R1: While reset is asserted, and after it is released: `in_ready`=1, `out_valid`=0, `out_pred`=0 and `out_gain`=0. Both windows and the stored previous prediction are cleared to zero.
- R2: A sample is taken on a clock edge where `in_valid` and `in_ready` are both 1. After that edge `in_ready` stays 0 until the edge where `out_valid` and `out_ready` are both 1. While `out_valid`=1 and `out_ready`=0, the outputs hold their values.
- R3: The error coefficient g is `err_coef` (Q0.8, 256 = 1.0), saturated to 256 when larger. The smoothed error is d = floor((g·Em + (256−g)·|P−x|) / 256). Here Em is the sum of the error window before insertion shifted right by 3, P is the previous prediction (0 after reset), and x is the new sample.
- R4: After d is inserted, let M be the largest entry of the error window. When M > 0, `out_gain` = 256 − floor(d·256 / M). It is a Q0.8 value on 9 bits.
- R5: When M = 0, `out_gain` is 256 (1.0) and no division takes place.
- R6: `out_pred` = floor((G·Hm + (256−G)·x) / 256). G is the gain and Hm is the sum of the observation window before x is inserted, shifted right by 3. The result becomes the stored previous prediction.
- R7: Each window holds the 8 most recent entries. Pushing a new entry drops the oldest one from both its content and its running sum.
- R8: `out_gain` never exceeds 256 while `out_valid` is 1.
- R9: `out_valid` rises no more than 28 clock cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_coef | input | 9 | Error-filter coefficient, Q0.8, saturated at 256 |
| in_valid | input | 1 | Sample available |
| in_ready | output | 1 | Estimator can take a sample |
| in_obs | input | 16 | Observed value, unsigned Q8.8 |
| out_valid | output | 1 | Prediction available |
| out_ready | input | 1 | Consumer takes the prediction |
| out_pred | output | 16 | Predicted next value, unsigned Q8.8 |
| out_gain | output | 9 | Smoothing gain used, Q0.8 |

## Verification
The assertions check on every cycle that the output is held under back-pressure, that only one sample is in flight, that the gain stays within 1.0 and that the divider quotient is never above 256. The arithmetic of the estimator can only be shown by the bench's scenarios. These cover the smoothed error, the gain division, the zero-maximum case, window eviction and coefficient saturation. A bench-side model is stepped over swept coefficients and several sample patterns, with random stalls on the output.

// File: rtl/est_pkg.sv
`timescale 1ns/1ps
package est_pkg;
  localparam int VAL_W    = 16;
  localparam int FRAC_W   = 8;
  localparam int WIN_LOG2 = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_WAIT = 2'd2,
    ST_OUT  = 2'd3
  } est_state_e;
endpackage

// File: rtl/est_window.sv
`timescale 1ns/1ps
// Sliding window of 2**LOG2 entries with a running sum; optional maximum.
module est_window #(
  parameter int W       = 16,
  parameter int LOG2    = 3,
  parameter bit HAS_MAX = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [W-1:0]        din,
  output logic [W-1:0]        mean,
  output logic [W-1:0]        maxv
);
  localparam int DEPTH = 1 << LOG2;
  localparam int SW    = W + LOG2;

  logic [W-1:0]  mem [DEPTH];
  logic [SW-1:0] sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      sum <= '0;
    end else if (push) begin
      for (int i = DEPTH - 1; i > 0; i--) mem[i] <= mem[i-1];
      mem[0] <= din;
      sum    <= sum - SW'(mem[DEPTH-1]) + SW'(din);
    end
  end

  assign mean = sum[LOG2 +: W];

  generate
    if (HAS_MAX) begin : g_max
      always_comb begin
        maxv = mem[0];
        for (int i = 1; i < DEPTH; i++)
          if (mem[i] > maxv) maxv = mem[i];
      end
    end else begin : g_nomax
      assign maxv = '0;
    end
  endgenerate
endmodule

// File: rtl/est_blend.sv
`timescale 1ns/1ps
// res = floor((k*a + (ONE-k)*b) / ONE), k in Q0.FW with ONE = 2**FW.
module est_blend #(
  parameter int W  = 16,
  parameter int FW = 8
) (
  input  logic [FW:0]  k,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int PW = W + FW + 2;
  localparam logic [FW:0] ONE = {1'b1, {FW{1'b0}}};

  logic [FW:0]   kc;
  logic [PW-1:0] acc;

  always_comb begin
    kc  = ONE - k;
    acc = PW'(k) * PW'(a) + PW'(kc) * PW'(b);
    res = acc[FW +: W];
  end
endmodule

// File: rtl/est_divider.sv
`timescale 1ns/1ps
// Restoring divider, one quotient bit per cycle, NW cycles per division.
module est_divider #(
  parameter int NW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem;
  logic [NW-1:0] shq;
  logic [DW-1:0] dvs;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [DW:0]   trial;

  assign trial = {rem, shq[NW-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      shq  <= '0;
      dvs  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem  <= '0;
        shq  <= dividend;
        dvs  <= divisor;
        cnt  <= CW'(NW);
        busy <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, dvs}) begin
          rem <= DW'(trial - {1'b0, dvs});
          shq <= {shq[NW-2:0], 1'b1};
        end else begin
          rem <= trial[DW-1:0];
          shq <= {shq[NW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = shq;
endmodule

// File: rtl/adaptive_rate_est.sv
`timescale 1ns/1ps
module adaptive_rate_est #(
  parameter int VW = est_pkg::VAL_W,
  parameter int FW = est_pkg::FRAC_W,
  parameter int WL = est_pkg::WIN_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW:0]   err_coef,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_obs,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_pred,
  output logic [FW:0]   out_gain
);
  import est_pkg::*;

  localparam int GW = FW + 1;
  localparam int NW = VW + FW;
  localparam logic [GW-1:0] ONE = {1'b1, {FW{1'b0}}};

  est_state_e    state;
  logic [VW-1:0] x_q, hmean_q, delta_q, prev_pred;
  logic [VW-1:0] obs_mean, obs_max, err_mean, err_max;
  logic [VW-1:0] e_abs, delta_c, pred_c;
  logic [GW-1:0] coef_sat, gain_c;
  logic          accept, div_start, div_done, capture;
  logic [NW-1:0] div_quot;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;

  // Smoothed error for the incoming sample (R3)
  always_comb begin
    coef_sat = (err_coef > ONE) ? ONE : err_coef;
    e_abs    = (prev_pred > in_obs) ? (prev_pred - in_obs) : (in_obs - prev_pred);
  end

  est_blend #(.W(VW), .FW(FW)) u_err_mix (
    .k(coef_sat), .a(err_mean), .b(e_abs), .res(delta_c)
  );

  est_window #(.W(VW), .LOG2(WL), .HAS_MAX(1'b0)) u_obs_win (
    .clk(clk), .rst_n(rst_n), .push(accept), .din(in_obs),
    .mean(obs_mean), .maxv(obs_max)
  );

  est_window #(.W(VW), .LOG2(WL), .HAS_MAX(1'b1)) u_err_win (
    .clk(clk), .rst_n(rst_n), .push(accept), .din(delta_c),
    .mean(err_mean), .maxv(err_max)
  );

  assign div_start = (state == ST_DIV) && (err_max != '0);

  est_divider #(.NW(NW), .DW(VW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend({delta_q, {FW{1'b0}}}), .divisor(err_max),
    .done(div_done), .quot(div_quot)
  );

  // Gain selection (R4, R5)
  always_comb begin
    if (err_max == '0)
      gain_c = ONE;
    else if (div_quot > NW'(ONE))
      gain_c = '0;
    else
      gain_c = ONE - div_quot[GW-1:0];
  end

  est_blend #(.W(VW), .FW(FW)) u_pred_mix (
    .k(gain_c), .a(hmean_q), .b(x_q), .res(pred_c)
  );

  assign capture = ((state == ST_DIV) && (err_max == '0)) ||
                   ((state == ST_WAIT) && div_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      x_q       <= '0;
      hmean_q   <= '0;
      delta_q   <= '0;
      prev_pred <= '0;
      out_valid <= 1'b0;
      out_pred  <= '0;
      out_gain  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          x_q     <= in_obs;
          hmean_q <= obs_mean;
          delta_q <= delta_c;
          state   <= ST_DIV;
        end
        ST_DIV:  if (!capture) state <= ST_WAIT;
        ST_WAIT: ;
        ST_OUT:  if (out_ready) begin
          out_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (capture) begin
        out_pred  <= pred_c;
        out_gain  <= gain_c;
        prev_pred <= pred_c;
        out_valid <= 1'b1;
        state     <= ST_OUT;
      end
    end
  end
endmodule

// File: rtl/rate_est_check.sv
`timescale 1ns/1ps
module rate_est_check #(
  parameter int VW = 16,
  parameter int GW = 9,
  parameter int NW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_pred,
  input logic [GW-1:0] out_gain,
  input logic          div_done,
  input logic [NW-1:0] div_quot
);
  localparam logic [GW-1:0] ONE = {1'b1, {(GW-1){1'b0}}};

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pred) && $stable(out_gain)));

  assert_one_inflight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_no_accept_while_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_gain_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_gain <= ONE));

  assert_quot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (div_quot <= NW'(ONE)));
endmodule

bind adaptive_rate_est rate_est_check #(.VW(VW), .GW(GW), .NW(NW)) u_check (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pred(out_pred),
  .out_gain(out_gain), .div_done(div_done), .div_quot(div_quot)
);

// File: tb/tb_adaptive_rate_est.sv
`timescale 1ns/1ps
module tb_adaptive_rate_est;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  err_coef = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_obs = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_pred;
  logic [8:0]  out_gain;

  int n_total = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  int lfsr = 32'h1ACE5;

  always #5 clk = ~clk;

  adaptive_rate_est dut (
    .clk(clk), .rst_n(rst_n), .err_coef(err_coef), .in_valid(in_valid),
    .in_ready(in_ready), .in_obs(in_obs), .out_valid(out_valid),
    .out_ready(out_ready), .out_pred(out_pred), .out_gain(out_gain)
  );

  // Reference model state
  longint oh[8], eh[8];
  longint osum, esum, pp, m_gain, m_pred;
  bit     m_emax0;

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp, input string what);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin oh[i] = 0; eh[i] = 0; end
    osum = 0; esum = 0; pp = 0;
  endtask

  task automatic model_step(input longint x, input longint coef);
    longint g, e, em, om, d, emax;
    g  = (coef > 256) ? 256 : coef;
    e  = (pp > x) ? pp - x : x - pp;
    em = esum >> 3;
    om = osum >> 3;
    d  = (g * em + (256 - g) * e) >> 8;
    osum = osum - oh[7] + x;
    esum = esum - eh[7] + d;
    for (int i = 7; i > 0; i--) begin oh[i] = oh[i-1]; eh[i] = eh[i-1]; end
    oh[0] = x; eh[0] = d;
    emax = 0;
    for (int i = 0; i < 8; i++) if (eh[i] > emax) emax = eh[i];
    m_emax0 = (emax == 0);
    m_gain  = m_emax0 ? 256 : 256 - ((d << 8) / emax);
    m_pred  = (m_gain * om + (256 - m_gain) * x) >> 8;
    pp = m_pred;
  endtask

  task automatic do_reset();
    in_valid = 1'b0; out_ready = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", in_ready, 1, "in_ready in reset");
    chk(out_valid == 1'b0, "R1", out_valid, 0, "out_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", {in_ready, out_valid}, 2, "handshake after reset");
    chk(out_pred == 16'd0 && out_gain == 9'd0, "R1", out_pred + out_gain, 0, "outputs after reset");
    model_reset();
  endtask

  task automatic run_sample(input logic [15:0] x, input string tag);
    int lat, stall;
    logic [15:0] hp;
    logic [8:0]  hg;
    chk(in_ready == 1'b1, "R2", in_ready, 1, "ready before sample");
    in_valid = 1'b1; in_obs = x;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2", in_ready, 0, "ready drops after accept");
    model_step(longint'(x), longint'(err_coef));
    lat = 1;
    while (!out_valid && lat < 100) begin @(negedge clk); lat++; end
    chk(lat <= 28, "R9", lat, 28, "latency bound");
    hp = out_pred; hg = out_gain;
    stall = next_rand() & 3;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_pred == hp && out_gain == hg && !in_ready, "R2",
          out_pred, hp, "hold under back-pressure");
    end
    chk(hg <= 9'd256, "R8", hg, 256, "gain bound");
    chk(longint'(hg) == m_gain, m_emax0 ? "R5" : "R4", hg, m_gain, "gain");
    chk(longint'(hp) == m_pred, tag, hp, m_pred, "prediction");
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R2", {out_valid, in_ready}, 1, "release after take");
  endtask

  initial begin
    int coefs[9] = '{0, 32, 96, 160, 224, 255, 256, 300, 511};
    @(negedge clk);

    // Zero-maximum path: full coefficient, first errors are all zero (R5)
    err_coef = 9'd256;
    do_reset();
    for (int i = 0; i < 12; i++) run_sample(16'h0500, "R5");

    // Coefficient sweep over pseudo-random samples (R4, R6)
    foreach (coefs[c]) begin
      err_coef = coefs[c][8:0];
      do_reset();
      for (int i = 0; i < 20; i++) run_sample(16'(next_rand()), "R6");
    end

    // Window eviction: a large value leaves the window after 8 pushes (R7)
    err_coef = 9'd128;
    do_reset();
    run_sample(16'hFFFF, "R7");
    for (int i = 0; i < 12; i++) run_sample(16'h0100, "R7");

    // Coefficient above 1.0 behaves as 1.0 on a ramp and alternation (R3)
    err_coef = 9'd400;
    do_reset();
    for (int i = 0; i < 12; i++) run_sample(16'(i * 16'h0180), "R3");
    for (int i = 0; i < 12; i++) run_sample((i % 2) ? 16'h2000 : 16'h0040, "R3");

    // Small coefficient on a step pattern (R3, R6)
    err_coef = 9'd16;
    do_reset();
    for (int i = 0; i < 24; i++) run_sample((i < 10) ? 16'h0300 : 16'h0900, "R3");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
      $finish;
    end
  end
endmodule